// File: doc/BRIEF.md
# Coarse Gain-Trim Search Sequencer

This block finds a coarse gain-trim setting for a 16-bit monitoring converter with no software involved. A start pulse begins a search. The block presets a 16-bit trim word and drives it out. It then runs a short successive-approximation search over the top four trim bits. Each trial asks the converter for a fresh sample and compares the sample with a fixed target code near the top of the scale. The comparison decides whether the trial bit stays set.

The search runs one extra trial that sets no bit. This lets an all-zero coarse field be measured as a candidate. In every trial the block tracks the absolute error. It keeps the trim that gave the smallest error, whether that trim is the one the search ends on or not. When the search ends, the winning trim is presented and a one-cycle program strobe is raised, so that outside logic can write the value to nonvolatile storage. If the converter goes silent, a cycle limit ends the search and raises an error flag.

Top module: `cal_sar_seq`

## Requirements
- R1: After reset, `trim_o`, `best_trim_o`, `conv_req_o`, `prog_req_o`, `done_o`, `busy_o` and `timeout_err_o` are all zero.
- R2: A start pulse while idle loads the trim word with 0x0FFF. Bits 11..0 of `trim_o` then stay all ones for the whole search.
- R3: The search makes exactly five trials, on bit positions 15, 14, 13, 12 and 11 in that order. Before each trial at positions 15 to 12, that bit is set in the trim. The trial at position 11 adds no bit.
- R4: The error of a trial is the captured sample minus 63888, taken as a signed value. If the error is zero or positive, the bit set for that trial is cleared before the next trial. If the error is negative, the bit is kept.
- R5: Each trial raises `conv_req_o` for exactly one cycle, with the trial trim already on `trim_o`. The block accepts only a `conv_valid_i` that arrives after the cycle in which `conv_req_o` is high. A valid pulse in the request cycle itself is ignored.
- R6: The best error starts above 1,000,000, so the first trial is always recorded. A later trial replaces the recorded trim only when its absolute error is strictly smaller. On a tie, the earlier trial is kept.
- R7: After the fifth trial, `best_trim_o` holds the recorded trim and `prog_req_o` is high for exactly one cycle. From the next cycle, `done_o` stays high and `busy_o` stays low until the next start.
- R8: If no accepted `conv_valid_i` arrives within `TIMEOUT_CYC` cycles of waiting, the search aborts. `timeout_err_o` is set, `busy_o` drops, and no program strobe is issued. The next start clears `timeout_err_o`.
- R9: A start pulse during a search is ignored. The sequence of trial trims and the final result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a search (accepted when idle) |
| conv_valid_i | input | 1 | Converter sample ready |
| conv_data_i | input | 16 | Converter sample |
| trim_o | output | 16 | Trim word applied to the converter |
| conv_req_o | output | 1 | One-cycle conversion request |
| best_trim_o | output | 16 | Best trim found so far; final when `prog_req_o` or `done_o` |
| prog_req_o | output | 1 | One-cycle request to store `best_trim_o` |
| done_o | output | 1 | Search completed |
| busy_o | output | 1 | Search in progress |
| timeout_err_o | output | 1 | Last search aborted for lack of a sample |

## Verification
A behavioural converter model returns a saturated linear function of the coarse field. Its offset and slope are chosen to produce four distinct cases:
- every bit is kept because the readings stay low;
- the search climbs to an exact hit in the middle of the range;
- the best result is an early overshoot rather than the trim the search ends on;
- readings saturate, so errors tie, and only the bitless last trial reaches zero error, which selects a zero coarse code.

One run injects a bogus zero-valued valid in each request cycle; this exposes any design that accepts an in-flight conversion. Another run injects a stray start mid-search. A silent-converter run checks when the abort fires, and a run after it checks that the search recovers.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETBIT,
        S_REQ,
        S_WAIT,
        S_EVAL,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/cal_err_calc.sv
module cal_err_calc #(
    parameter int DATA_W = 16,
    parameter int TARGET = 63888,
    parameter int ERR_W  = 21
) (
    input  logic [DATA_W-1:0]      sample_i,
    output logic signed [DATA_W:0] err_o,
    output logic                   nonneg_o,
    output logic [ERR_W-1:0]       abs_o
);
    localparam logic [DATA_W-1:0] TGT = DATA_W'(TARGET);

    logic [DATA_W:0] mag;

    always_comb begin
        err_o    = $signed({1'b0, sample_i}) - $signed({1'b0, TGT});
        nonneg_o = ~err_o[DATA_W];
        mag      = err_o[DATA_W] ? (~err_o + 1'b1) : err_o;
        abs_o    = {{(ERR_W-DATA_W-1){1'b0}}, mag};
    end
endmodule

// File: rtl/cal_best_track.sv
module cal_best_track #(
    parameter int DATA_W = 16,
    parameter int ERR_W  = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              update_i,
    input  logic [ERR_W-1:0]  abs_err_i,
    input  logic [DATA_W-1:0] trim_i,
    output logic [DATA_W-1:0] best_trim_o,
    output logic [ERR_W-1:0]  best_err_o
);
    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] trim;
    } best_t;

    best_t best_d, best_q;

    always_comb begin
        best_d = best_q;
        if (init_i) begin
            best_d.err  = '1;
            best_d.trim = '0;
        end else if (update_i && (abs_err_i < best_q.err)) begin
            best_d.err  = abs_err_i;
            best_d.trim = trim_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_q.err  <= '1;
            best_q.trim <= '0;
        end else begin
            best_q <= best_d;
        end
    end

    assign best_trim_o = best_q.trim;
    assign best_err_o  = best_q.err;

    // R6: the recorded error never grows within a search
    p_best_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> (best_q.err <= $past(best_q.err)));

    // R6: a search always starts from an error above 1,000,000
    p_best_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (best_q.err > ERR_W'(1000000)));
endmodule

// File: rtl/cal_watch.sv
module cal_watch #(
    parameter int LIMIT = 4096,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)               cnt_d = '0;
        else if (cnt_q <= LAST)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = run_i && (cnt_q == LAST);

    // R8: the wait counter never runs past one step beyond its limit
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LIMIT));
endmodule

// File: rtl/cal_sar_seq.sv
module cal_sar_seq
    import cal_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int COARSE_W    = 4,
    parameter int TARGET      = 63888,
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              conv_valid_i,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic [DATA_W-1:0] trim_o,
    output logic              conv_req_o,
    output logic [DATA_W-1:0] best_trim_o,
    output logic              prog_req_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              timeout_err_o
);
    localparam int FINE_W  = DATA_W - COARSE_W;
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int ERR_W   = DATA_W + 5;
    localparam logic [IDX_W-1:0]  TOP_IDX = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0]  LOW_IDX = IDX_W'(FINE_W - 1);
    localparam logic [DATA_W-1:0] PRESET  = DATA_W'((1 << FINE_W) - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [DATA_W-1:0] trim;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sample;
        logic              done;
        logic              terr;
    } seq_t;

    seq_t s_d, s_q;

    logic signed [DATA_W:0] err;
    logic                   nonneg;
    logic [ERR_W-1:0]       abs_err;
    logic [ERR_W-1:0]       best_err;
    logic                   expire;
    logic                   launch;

    cal_err_calc #(.DATA_W(DATA_W), .TARGET(TARGET), .ERR_W(ERR_W)) u_err (
        .sample_i (s_q.sample),
        .err_o    (err),
        .nonneg_o (nonneg),
        .abs_o    (abs_err)
    );

    cal_best_track #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_best (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (launch),
        .update_i    (s_q.state == S_EVAL),
        .abs_err_i   (abs_err),
        .trim_i      (s_q.trim),
        .best_trim_o (best_trim_o),
        .best_err_o  (best_err)
    );

    cal_watch #(.LIMIT(TIMEOUT_CYC)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (s_q.state == S_WAIT),
        .expire_o (expire)
    );

    assign launch = (s_q.state == S_IDLE) && start_i;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            S_IDLE: begin
                if (start_i) begin
                    s_d.trim  = PRESET;
                    s_d.idx   = TOP_IDX;
                    s_d.done  = 1'b0;
                    s_d.terr  = 1'b0;
                    s_d.state = S_SETBIT;
                end
            end
            S_SETBIT: begin
                // the extra lowest trial adds no bit
                if (s_q.idx > LOW_IDX) s_d.trim[s_q.idx] = 1'b1;
                s_d.state = S_REQ;
            end
            S_REQ: begin
                // any valid seen now belongs to an older conversion
                s_d.state = S_WAIT;
            end
            S_WAIT: begin
                if (conv_valid_i) begin
                    s_d.sample = conv_data_i;
                    s_d.state  = S_EVAL;
                end else if (expire) begin
                    s_d.terr  = 1'b1;
                    s_d.state = S_IDLE;
                end
            end
            S_EVAL: begin
                if (nonneg && (s_q.idx > LOW_IDX)) s_d.trim[s_q.idx] = 1'b0;
                if (s_q.idx == LOW_IDX) begin
                    s_d.state = S_FINISH;
                end else begin
                    s_d.idx   = s_q.idx - 1'b1;
                    s_d.state = S_SETBIT;
                end
            end
            S_FINISH: begin
                s_d.done  = 1'b1;
                s_d.state = S_IDLE;
            end
            default: s_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state  <= S_IDLE;
            s_q.trim   <= '0;
            s_q.idx    <= '0;
            s_q.sample <= '0;
            s_q.done   <= 1'b0;
            s_q.terr   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign trim_o        = s_q.trim;
    assign conv_req_o    = (s_q.state == S_REQ);
    assign prog_req_o    = (s_q.state == S_FINISH);
    assign done_o        = s_q.done;
    assign busy_o        = (s_q.state != S_IDLE);
    assign timeout_err_o = s_q.terr;

    // R2: the fine field holds all ones throughout a search
    p_fine_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (trim_o[FINE_W-1:0] == PRESET[FINE_W-1:0]));

    // R5: a request lasts a single cycle and the trim is steady across it
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req_o |=> (!conv_req_o && $stable(trim_o)));

    // R7: the program strobe is one cycle and done follows it
    p_prog_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |=> (!prog_req_o && done_o && !busy_o));

    // R7: done and busy never overlap
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    // R8: an abort leaves the block idle without a program strobe
    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err_o) |-> (!busy_o && !done_o && !$past(prog_req_o)));

    // R4: the coarse field changes only at its own trial position
    p_coarse_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |->
            ($countones(trim_o ^ $past(trim_o)) <= 1));
endmodule

// File: tb/cal_sar_seq_bench.sv
module cal_sar_seq_bench;
    localparam int TO  = 40;
    localparam int LAT = 3;
    localparam int TGT = 63888;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        conv_valid_i = 1'b0;
    logic [15:0] conv_data_i = '0;
    logic [15:0] trim_o;
    logic        conv_req_o;
    logic [15:0] best_trim_o;
    logic        prog_req_o;
    logic        done_o;
    logic        busy_o;
    logic        timeout_err_o;

    int errors = 0;
    int checks = 0;

    int  m_offset = 0;
    int  m_step   = 0;
    bit  adc_on   = 1'b1;
    bit  stray_on = 1'b0;

    logic [15:0] trial_q[$];
    logic [15:0] best_q[$];

    always #10 clk = ~clk;

    cal_sar_seq #(.TIMEOUT_CYC(TO)) u_cal_sar_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .conv_valid_i  (conv_valid_i),
        .conv_data_i   (conv_data_i),
        .trim_o        (trim_o),
        .conv_req_o    (conv_req_o),
        .best_trim_o   (best_trim_o),
        .prog_req_o    (prog_req_o),
        .done_o        (done_o),
        .busy_o        (busy_o),
        .timeout_err_o (timeout_err_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int model(input logic [15:0] t);
        int v;
        v = m_offset + m_step * int'(t[15:12]);
        if (v > 65535) v = 65535;
        if (v < 0) v = 0;
        return v;
    endfunction

    // driver: computes the expected trial trims and result, then starts
    task automatic run_cal(input int off, input int stp, input bit stray, input bit restart);
        logic [15:0] t;
        int best, bt, e, ae;
        m_offset = off;
        m_step   = stp;
        stray_on = stray;
        t = 16'h0FFF;
        best = 2000000;
        bt = 0;
        for (int b = 15; b >= 11; b--) begin
            if (b > 11) t[b] = 1'b1;
            trial_q.push_back(t);
            e = model(t) - TGT;
            ae = (e < 0) ? -e : e;
            if (ae < best) begin
                best = ae;
                bt = int'(t);
            end
            if (e >= 0 && b > 11) t[b] = 1'b0;
        end
        best_q.push_back(16'(bt));
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check(busy_o && trim_o[11:0] == 12'hFFF, "R2 preset", int'(trim_o), 16'h0FFF);
        if (restart) begin
            repeat (6) @(negedge clk);
            start_i = 1'b1;          // R9: ignored while busy
            @(negedge clk); start_i = 1'b0;
        end
        for (int i = 0; i < 400 && !done_o; i++) @(negedge clk);
        check(done_o && !busy_o, "R7 done", int'(done_o), 1);
        repeat (3) @(negedge clk);
        check(done_o && !busy_o && !prog_req_o, "R7 done held", int'(done_o), 1);
        check(trial_q.size() == 0, "R3 trial count", trial_q.size(), 0);
        check(best_q.size() == 0, "R7 result count", best_q.size(), 0);
        check(!timeout_err_o, "R8 no abort", int'(timeout_err_o), 0);
    endtask

    // converter model
    initial begin
        logic [15:0] cap;
        forever begin
            @(negedge clk);
            if (conv_req_o && adc_on) begin
                cap = trim_o;
                if (stray_on) begin
                    conv_valid_i = 1'b1;  // R5: stale sample in the request cycle
                    conv_data_i  = 16'h0000;
                end
                @(negedge clk);
                conv_valid_i = 1'b0;
                repeat (LAT - 1) @(negedge clk);
                conv_valid_i = 1'b1;
                conv_data_i  = 16'(model(cap));
                @(negedge clk);
                conv_valid_i = 1'b0;
            end
        end
    end

    // monitor: compares trial trims and the final result with the queues
    initial begin
        logic [15:0] exp;
        forever begin
            @(negedge clk);
            if (rst_n && conv_req_o) begin
                if (trial_q.size() == 0) check(1'b0, "R3 unexpected trial", int'(trim_o), 0);
                else begin
                    exp = trial_q.pop_front();
                    check(trim_o == exp, "R3 R4 trial trim", int'(trim_o), int'(exp));
                end
            end
            if (rst_n && prog_req_o) begin
                if (best_q.size() == 0) check(1'b0, "R8 unexpected program", int'(best_trim_o), 0);
                else begin
                    exp = best_q.pop_front();
                    check(best_trim_o == exp, "R6 R7 best trim", int'(best_trim_o), int'(exp));
                end
            end
        end
    end

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(trim_o == 0 && best_trim_o == 0, "R1 trims", int'(trim_o), 0);
        check(!conv_req_o && !prog_req_o, "R1 strobes", int'(conv_req_o), 0);
        check(!done_o && !busy_o && !timeout_err_o, "R1 flags", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_cal(0, 4000, 1'b1, 1'b0);      // all low: keeps every bit, stale valids
        check(best_trim_o == 16'hFFFF, "R4 all kept", int'(best_trim_o), 16'hFFFF);
        run_cal(60000, 1296, 1'b0, 1'b0);  // exact hit at coarse 3
        check(best_trim_o == 16'h3FFF, "R6 exact", int'(best_trim_o), 16'h3FFF);
        run_cal(40000, 3000, 1'b0, 1'b1);  // early overshoot wins, stray start
        check(best_trim_o == 16'h8FFF, "R9 R6 overshoot", int'(best_trim_o), 16'h8FFF);
        run_cal(63888, 5000, 1'b1, 1'b0);  // ties then zero coarse code
        check(best_trim_o == 16'h0FFF, "R3 zero code", int'(best_trim_o), 16'h0FFF);

        // R8: silent converter
        adc_on = 1'b0;
        trial_q.push_back(16'h8FFF);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < 10 && !conv_req_o; i++) @(negedge clk);
        check(conv_req_o, "R8 request", int'(conv_req_o), 1);
        repeat (TO - 1) @(negedge clk);
        check(!timeout_err_o && busy_o, "R8 early", int'(timeout_err_o), 0);
        repeat (3) @(negedge clk);
        check(timeout_err_o && !busy_o && !done_o, "R8 abort", int'(timeout_err_o), 1);
        adc_on = 1'b1;
        run_cal(40000, 3000, 1'b0, 1'b0);  // recovery clears the flag
        summary();
    end
endmodule